// File: doc/BRIEF.md
# Backplane Interrupter Control Register

This block is a single 16-bit control register that turns events from inside a module into a request on a shared backplane. It watches three request inputs: a trigger routing matrix, a mailbox written by the local processor, and a mailbox written by the DSP. A rising edge on any of these inputs sets a pending flag for that source. Software can also raise a test request by writing a 0 to a bit that does not keep the value written.

Each source has an active-low mask bit. A global interrupter enable bit is also active-low. A 3-bit line-select code picks one of seven active-low request lines. The code counts downward from the highest line, and the all-ones code drives no line. Software acknowledges a request by pulsing the matching bit of a clear input.

The acknowledge cycle, the return of a status/ID and any handler function are outside this block. The handler fields read back as fixed constants. A hard reset and a synchronous soft reset both return the register to all ones and drop every pending request.

Top module: `irq_ctl_reg`

## Requirements
- R1: After a hard reset (rst_n low), rdata reads 0xFFFF and all of irq_n[7:1] are high.
- R2: The following bits always read 1, and writing 0 to them has no lasting effect on rdata: bits 15..12 (unused), bit 11 (test), bit 6 (handler enable) and bits 2..0 (handler line).
- R3: A write (sel=1 and wr_en=1 at a clock edge) stores the writable bits, and they read back unchanged. The writable bits are: bit 10 masks the DSP mailbox source (src_req[2]), bit 9 masks the local-processor mailbox source (src_req[1]), bit 8 masks the trigger-matrix source (src_req[0]), bit 7 disables the interrupter, and bits 5..3 hold the line code.
- R4: Line code c in 0..6 drives IRQ(7-c) low, which is irq_n[7-c]. Code 7 drives no line. At most one irq_n bit is ever low.
- R5: A rising edge on src_req[k] sets pending flag k. pend_clr[k] clears it, but a rise in the same cycle wins over the clear. A source held high does not set the flag again.
- R6: A pending source drives the line only while its mask bit is 0. Clearing the mask bit later, with the flag still pending, asserts the line.
- R7: While bit 7 is 1, no line is driven. Writing bit 7 to 0 asserts the line if a request is pending and unmasked.
- R8: Writing 0 to bit 11 sets a test pending flag. This flag ignores the source masks but follows the bit 7 and line-code rules. pend_clr[3] clears it.
- R9: A soft reset (soft_rst high at a clock edge) returns rdata to 0xFFFF and clears all pending flags.
- R10: A write strobe with sel low changes neither rdata nor irq_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| sel | input | 1 | Register select strobe |
| wr_en | input | 1 | Write enable, used with sel |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Register contents |
| src_req | input | 3 | Source requests: [0] trigger matrix, [1] local-processor mailbox, [2] DSP mailbox |
| pend_clr | input | 4 | Pending clear: [2:0] per source, [3] test |
| irq_n | output | 7 | Active-low request lines; irq_n[i] is IRQi |

## Verification
The bench steps through all eight line codes. A design that decoded the code upward, or treated code 7 as a line, would pull the wrong irq_n bit low.

A source is held high after its flag is cleared. A level-sensitive design would assert the line again straight away. Another case presses a rising edge and a clear in the same cycle. A design that let the clear win would lose the request.

Requests raised while masked or while the interrupter is disabled must come out once that bit is written to 0. A design that gated the capture with the mask, instead of the output, would drop them.

The test bit is written as 0 with every source mask set to 1. The bench then expects the line low and the bit still reading 1. A design that stored the bit, or masked the test flag, would fail this case.

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            sel,
  input  logic            wr_en,
  input  logic [15:0]     wdata,
  output logic [15:0]     rdata,
  input  logic [NSRC-1:0] src_req,
  input  logic [NSRC:0]   pend_clr,
  output logic [7:1]      irq_n
);
  logic [NSRC-1:0] mask_q;
  logic            dis_q;
  logic [2:0]      line_q;
  logic [NSRC-1:0] src_q;
  logic [NSRC:0]   pend_q;
  logic            wr;
  logic            fire;

  assign wr = sel && wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      dis_q  <= 1'b1;
      line_q <= 3'b111;
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q <= src_req;
      if (soft_rst) begin
        mask_q <= '1;
        dis_q  <= 1'b1;
        line_q <= 3'b111;
        pend_q <= '0;
      end else begin
        if (wr) begin
          mask_q <= wdata[8 +: NSRC];
          dis_q  <= wdata[7];
          line_q <= wdata[5:3];
        end
        pend_q[NSRC-1:0] <= (pend_q[NSRC-1:0] & ~pend_clr[NSRC-1:0]) | (src_req & ~src_q);
        pend_q[NSRC]     <= (pend_q[NSRC] & ~pend_clr[NSRC]) | (wr & ~wdata[11]);
      end
    end
  end

  assign fire = ((|(pend_q[NSRC-1:0] & ~mask_q)) || pend_q[NSRC]) && !dis_q && (line_q != 3'b111);

  always_comb begin
    irq_n = '1;
    if (fire) irq_n[7 - int'(line_q)] = 1'b0;
  end

  assign rdata = {4'hF, 1'b1, mask_q, dis_q, 1'b1, line_q, 3'b111};
endmodule

// File: rtl/irq_ctl_reg_chk.sv
module irq_ctl_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        sel,
  input logic        wr_en,
  input logic [15:0] rdata,
  input logic [2:0]  src_req,
  input logic [7:1]  irq_n
);
  p_one_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~irq_n) <= 1);

  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[15:11] == 5'h1F && rdata[6] && rdata[2:0] == 3'b111);

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7] |-> &irq_n);

  p_code7_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[5:3] == 3'b111 |-> &irq_n);

  p_soft_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rdata == 16'hFFFF && &irq_n));

  p_rise_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(src_req[0]) && !rdata[8] && !rdata[7] && rdata[5:3] != 3'b111
     && !soft_rst && !(sel && wr_en)) |=> !(&irq_n));
endmodule

bind irq_ctl_reg irq_ctl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sel(sel), .wr_en(wr_en),
  .rdata(rdata), .src_req(src_req), .irq_n(irq_n)
);

// File: tb/irq_ctl_reg_tb.sv
module irq_ctl_reg_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        soft_rst = 0;
  logic        sel = 0;
  logic        wr_en = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  src_req = '0;
  logic [3:0]  pend_clr = '0;
  logic [7:1]  irq_n;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irq_ctl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sel(sel), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .src_req(src_req), .pend_clr(pend_clr), .irq_n(irq_n)
  );

  function automatic logic [15:0] cfg(input logic [2:0] m, input logic d, input logic [2:0] l);
    return {4'hF, 1'b1, m, d, 1'b1, l, 3'b111};
  endfunction

  function automatic logic [7:1] line_exp(input int c);
    return (c == 7) ? 7'h7F : ~(7'b1 << (6 - c));
  endfunction

  task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s rdata act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk7(input string tag, input logic [7:1] act, input logic [7:1] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s irq_n act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d, input logic s = 1'b1);
    @(negedge clk);
    sel = s; wr_en = 1; wdata = d;
    @(negedge clk);
    sel = 0; wr_en = 0; wdata = '0;
  endtask

  task automatic rise(input int k);
    @(negedge clk); src_req[k] = 1;
    @(negedge clk);
  endtask

  task automatic clr_all();
    @(negedge clk); src_req = '0; pend_clr = 4'hF;
    @(negedge clk); pend_clr = '0;
  endtask

  task automatic t_hard_reset();
    chk16("R1 reset value", rdata, 16'hFFFF);
    chk7("R1 reset lines", irq_n, 7'h7F);
  endtask

  task automatic t_rw();
    wr(16'h0000);
    chk16("R2 fixed bits after zero write", rdata, 16'hF847);
    chk7("R8 zero write fires test on IRQ7", irq_n, 7'b0111111);
    clr_all();
    chk7("R8 test cleared", irq_n, 7'h7F);
    wr(16'h0A28);
    chk16("R3 pattern readback", rdata, 16'hFA6F);
  endtask

  task automatic t_nosel();
    wr(16'h0000, 1'b0);
    chk16("R10 no sel keeps rdata", rdata, 16'hFA6F);
    chk7("R10 no sel no irq", irq_n, 7'h7F);
  endtask

  task automatic t_lines();
    for (int c = 0; c < 8; c++) begin
      wr(cfg(3'b000, 1'b0, 3'(c)));
      rise(0);
      chk7($sformatf("R4 line code %0d", c), irq_n, line_exp(c));
      clr_all();
    end
  endtask

  task automatic t_mask();
    wr(cfg(3'b111, 1'b0, 3'd0));
    rise(0); rise(1); rise(2);
    chk7("R6 all masked quiet", irq_n, 7'h7F);
    wr(cfg(3'b101, 1'b0, 3'd2));
    chk7("R6 unmask lp mailbox drives IRQ5", irq_n, line_exp(2));
    clr_all();
    wr(cfg(3'b011, 1'b0, 3'd1));
    rise(2);
    chk7("R6 dsp mailbox unmasked drives IRQ6", irq_n, line_exp(1));
    clr_all();
  endtask

  task automatic t_disable();
    wr(cfg(3'b000, 1'b1, 3'd3));
    rise(1);
    chk7("R7 disabled quiet", irq_n, 7'h7F);
    wr(cfg(3'b000, 1'b0, 3'd3));
    chk7("R7 enable drives IRQ4", irq_n, line_exp(3));
    clr_all();
  endtask

  task automatic t_edge();
    wr(cfg(3'b000, 1'b0, 3'd4));
    rise(0);
    @(negedge clk); pend_clr = 4'b0001;
    @(negedge clk); pend_clr = '0;
    @(negedge clk);
    chk7("R5 held level does not re-set", irq_n, 7'h7F);
    src_req[0] = 0;
    @(negedge clk);
    src_req[0] = 1; pend_clr = 4'b0001;
    @(negedge clk); pend_clr = '0;
    chk7("R5 rise beats clear", irq_n, line_exp(4));
    clr_all();
  endtask

  task automatic t_test_bit();
    wr(cfg(3'b111, 1'b0, 3'd5) & ~16'h0800);
    chk7("R8 test ignores masks IRQ2", irq_n, line_exp(5));
    chk16("R8 test bit reads 1", rdata, cfg(3'b111, 1'b0, 3'd5));
    @(negedge clk); pend_clr = 4'b1000;
    @(negedge clk); pend_clr = '0;
    chk7("R8 test clear", irq_n, 7'h7F);
  endtask

  task automatic t_soft();
    wr(cfg(3'b000, 1'b0, 3'd6));
    rise(0);
    chk7("R9 pre soft reset IRQ1", irq_n, line_exp(6));
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
    chk16("R9 soft reset value", rdata, 16'hFFFF);
    wr(cfg(3'b000, 1'b0, 3'd6));
    chk7("R9 pending cleared", irq_n, 7'h7F);
    src_req = '0;
  endtask

  task automatic t_hard_again();
    rise(2);
    @(negedge clk); rst_n = 0; src_req = '0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk16("R1 hard reset value", rdata, 16'hFFFF);
    wr(cfg(3'b000, 1'b0, 3'd6));
    chk7("R1 hard reset clears pending", irq_n, 7'h7F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_hard_reset();
    t_rw();
    t_nosel();
    clr_all();
    t_lines();
    t_mask();
    t_disable();
    t_edge();
    t_test_bit();
    t_soft();
    t_hard_again();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule